// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Sequencer

This block owns an active-low reset line that is open-drain and shared with a pushbutton. It only ever drives an enable for the pull-down transistor. It also reads the line back, so it can tell when someone presses the button. When the line is idle and is pulled low from outside, the block takes the line over and holds it low for a debounce interval. It then lets go and looks again. If the button is still held, it waits for the release and then issues a reset pulse of fixed length.

A power-fail flag overrides all of this. While the flag is set, the line is held low. When the flag clears, the line stays low for a recovery interval, but only if the oscillator is running. If the oscillator is stopped, the line is released at once. All three intervals are parameters counted in pulses of a millisecond tick. The sensed pin passes through a two-flop synchronizer before it is used.

Top module: `pbrst_seq`

## Requirements
- R1: After reset, `pull_low` is 0 and the block is idle.
- R2: While idle, a high-to-low change on `pin_in` sets `pull_low` to 1 on the third rising clock edge after the change. That delay is two synchronizer flops plus the state register.
- R3: The debounce hold keeps `pull_low` at 1 for exactly `DEBOUNCE_MS` tick pulses, whatever `pin_in` does meanwhile.
- R4: If the line is back high when the debounce hold ends, no reset pulse follows and the block returns to idle.
- R5: If the line is still low after the debounce hold, `pull_low` stays 0 until the line goes high. `pull_low` then rises on the third clock edge after the release and stays 1 for exactly `ACTIVE_MS` tick pulses.
- R6: `pwr_fail` at 1 makes `pull_low` 1 on the next clock edge from any state, aborting any pushbutton sequence. The button has no effect while power is failing.
- R7: When `pwr_fail` returns to 0 with `osc_run` at 1, `pull_low` stays 1 for exactly `RECOVER_MS` further tick pulses and then drops to 0.
- R8: When `pwr_fail` returns to 0 with `osc_run` at 0, `pull_low` is 0 one clock edge later.
- R9: A new power failure during the recovery interval returns the block to the hold. A later recovery starts its count again from zero.
- R10: A line that rises again after the block stops driving it starts no new sequence. Only a fresh falling edge while idle does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pin_in | input | 1 | Sensed level of the reset line (asynchronous) |
| pwr_fail | input | 1 | Supply below threshold, synchronous |
| osc_run | input | 1 | Oscillator is running |
| pull_low | output | 1 | Enable for the open-drain pull-down |

## Verification
The assertions check properties that hold on every cycle:
- The line is held during a power failure.
- Release after power returns follows the oscillator flag.
- A debounce hold is entered only from idle.
- The debounce, pulse and recovery holds never outlast their tick budgets.

Other behaviour can only be shown by the bench scenarios, which model the wired line as the AND of the button and the pull-down:
- the exact three-edge latency through the synchronizer;
- the choice at the end of the debounce between a pulse and a return to idle;
- the absence of spurious sequences after the line is released.

// File: rtl/pbrst_seq.sv
module pbrst_seq #(
  parameter int DEBOUNCE_MS = 250,
  parameter int ACTIVE_MS   = 250,
  parameter int RECOVER_MS  = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pin_in,
  input  logic pwr_fail,
  input  logic osc_run,
  output logic pull_low
);
  localparam int SETTLE_CYC = 3;
  localparam int MAX_MS = (DEBOUNCE_MS > ACTIVE_MS) ?
                          ((DEBOUNCE_MS > RECOVER_MS) ? DEBOUNCE_MS : RECOVER_MS) :
                          ((ACTIVE_MS > RECOVER_MS) ? ACTIVE_MS : RECOVER_MS);
  localparam int CW = $clog2(MAX_MS + SETTLE_CYC + 1);

  localparam logic [2:0] S_IDLE   = 3'd0;
  localparam logic [2:0] S_DEB    = 3'd1;
  localparam logic [2:0] S_SETTLE = 3'd2;
  localparam logic [2:0] S_WAIT   = 3'd3;
  localparam logic [2:0] S_PULSE  = 3'd4;
  localparam logic [2:0] S_PFAIL  = 3'd5;
  localparam logic [2:0] S_RECOV  = 3'd6;

  logic [2:0]    state_q, state_nx;
  logic [CW-1:0] cnt_q, lim;
  logic          pin_s1, pin_s2, pin_d;
  logic          fall, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= 1'b1;
      pin_s2 <= 1'b1;
      pin_d  <= 1'b1;
    end else begin
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
      pin_d  <= pin_s2;
    end

  assign fall = pin_d & ~pin_s2;

  always_comb
    case (state_q)
      S_DEB:    lim = CW'(DEBOUNCE_MS - 1);
      S_PULSE:  lim = CW'(ACTIVE_MS - 1);
      S_RECOV:  lim = CW'(RECOVER_MS - 1);
      S_SETTLE: lim = CW'(SETTLE_CYC - 1);
      default:  lim = '0;
    endcase

  assign done = (state_q == S_SETTLE || ms_tick) && cnt_q == lim;

  always_comb begin
    state_nx = state_q;
    if (pwr_fail) state_nx = S_PFAIL;
    else
      case (state_q)
        S_IDLE:   if (fall) state_nx = S_DEB;
        S_DEB:    if (done) state_nx = S_SETTLE;
        S_SETTLE: if (done) state_nx = pin_s2 ? S_IDLE : S_WAIT;
        S_WAIT:   if (pin_s2) state_nx = S_PULSE;
        S_PULSE:  if (done) state_nx = S_IDLE;
        S_PFAIL:  state_nx = osc_run ? S_RECOV : S_IDLE;
        S_RECOV:  if (done) state_nx = S_IDLE;
        default:  state_nx = S_IDLE;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nx;
      if (state_nx != state_q)
        cnt_q <= '0;
      else if (state_q == S_SETTLE || ms_tick)
        cnt_q <= cnt_q + 1'b1;
    end

  assign pull_low = (state_q == S_DEB) | (state_q == S_PULSE) |
                    (state_q == S_PFAIL) | (state_q == S_RECOV);
endmodule

// File: rtl/pbrst_seq_chk.sv
module pbrst_seq_chk #(
  parameter int DEBOUNCE_MS = 250,
  parameter int ACTIVE_MS   = 250,
  parameter int RECOVER_MS  = 250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       pwr_fail,
  input logic       osc_run,
  input logic       pull_low,
  input logic [2:0] state_q
);
  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_DEB   = 3'd1;
  localparam logic [2:0] S_PULSE = 3'd4;
  localparam logic [2:0] S_RECOV = 3'd6;

  logic [2:0] prev_st;
  int         ticks_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_st  <= S_IDLE;
      ticks_in <= 0;
    end else begin
      prev_st <= state_q;
      if (state_q != prev_st) ticks_in <= ms_tick ? 1 : 0;
      else if (ms_tick) ticks_in <= ticks_in + 1;
    end

  a_r6_pfail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> pull_low);

  a_r7_recover_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_fail && $past(pwr_fail) && $past(rst_n) && osc_run) |=> pull_low);

  a_r8_osc_stopped_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_fail && $past(pwr_fail) && $past(rst_n) && !osc_run) |=> !pull_low);

  a_r2_deb_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DEB && prev_st != S_DEB && $past(rst_n)) |-> prev_st == S_IDLE);

  a_r3_deb_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DEB && prev_st == S_DEB) |-> ticks_in < DEBOUNCE_MS);

  a_r5_pulse_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PULSE && prev_st == S_PULSE) |-> ticks_in < ACTIVE_MS);

  a_r7_recover_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RECOV && prev_st == S_RECOV) |-> ticks_in < RECOVER_MS);
endmodule

bind pbrst_seq pbrst_seq_chk #(
  .DEBOUNCE_MS(DEBOUNCE_MS), .ACTIVE_MS(ACTIVE_MS), .RECOVER_MS(RECOVER_MS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_fail(pwr_fail),
  .osc_run(osc_run), .pull_low(pull_low), .state_q(state_q)
);

// File: tb/pbrst_seq_tb_top.sv
module pbrst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 5;
  localparam int ACT = 7;
  localparam int REC = 6;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic button = 1'b0;
  logic pwr_fail = 1'b0;
  logic osc_run = 1'b1;
  logic pull_low;
  logic pin_in;
  int checks = 0;
  int errors = 0;

  assign pin_in = ~(pull_low | button);

  pbrst_seq #(.DEBOUNCE_MS(DEB), .ACTIVE_MS(ACT), .RECOVER_MS(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .pwr_fail(pwr_fail), .osc_run(osc_run), .pull_low(pull_low));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (TDIV - 1) begin @(negedge clk); ms_tick = 1'b0; end
    @(negedge clk); ms_tick = 1'b1;
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int t);
    int guard = 0;
    t = 0;
    while (pull_low && guard < 2000) begin
      if (ms_tick) t++;
      step(1);
      guard++;
    end
  endtask

  task automatic quiet(input string req, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pull_low) highs++;
      step(1);
    end
    chk(req, highs, 0);
  endtask

  task automatic press_enter;
    button = 1'b1;
    step(2);
    chk("R2 not yet driven", int'(pull_low), 0);
    step(1);
    chk("R2 driven on third edge", int'(pull_low), 1);
  endtask

  task automatic power_return(input logic osc, input string tag);
    int t;
    while (ms_tick) step(1);
    osc_run = osc;
    pwr_fail = 1'b0;
    step(1);
    if (osc) begin
      chk({tag, " R7 still held"}, int'(pull_low), 1);
      measure(t);
      chk({tag, " R7 recovery ticks"}, t, REC);
    end else begin
      chk({tag, " R8 released at once"}, int'(pull_low), 0);
    end
    quiet({tag, " R10 no sequence after power"}, 6 * TDIV);
    osc_run = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t;
    step(4);
    rst_n = 1'b1;
    step(2);
    chk("R1 reset state", int'(pull_low), 0);
    quiet("R1 idle after reset", 3 * TDIV);

    // short presses released during the debounce hold
    for (int k = 1; k < DEB; k++) begin
      press_enter();
      t = 0;
      while (t < k) begin if (ms_tick) t++; step(1); end
      button = 1'b0;
      while (pull_low) begin if (ms_tick) t++; step(1); end
      chk("R3 debounce ticks (short)", t, DEB);
      quiet("R4 no pulse after short press", ACT * TDIV + 12);
    end

    // long presses, release some time after the debounce hold
    for (int m = 0; m < 4; m++) begin
      press_enter();
      measure(t);
      chk("R3 debounce ticks (long)", t, DEB);
      quiet("R5 line free while held", m * TDIV + 3);
      button = 1'b0;
      step(2);
      chk("R5 not yet pulsing", int'(pull_low), 0);
      step(1);
      chk("R5 pulse starts third edge", int'(pull_low), 1);
      measure(t);
      chk("R5 pulse ticks", t, ACT);
      quiet("R10 no retrigger after pulse", 5 * TDIV);
    end

    // power failure from each pushbutton state, both oscillator states
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        if (s >= 1) press_enter();
        if (s >= 2) begin measure(t); step(5); end
        if (s == 3) begin button = 1'b0; step(5); end
        if (s == 1) step(3);
        pwr_fail = 1'b1;
        step(1);
        chk("R6 forced low next edge", int'(pull_low), 1);
        button = ~button;
        step(3 * TDIV);
        button = 1'b0;
        step(2 * TDIV);
        chk("R6 held despite button", int'(pull_low), 1);
        power_return(logic'(o), "pf");
      end
    end

    // power failure during recovery
    pwr_fail = 1'b1;
    step(3);
    while (ms_tick) step(1);
    pwr_fail = 1'b0;
    step(2 * TDIV);
    chk("R9 in recovery", int'(pull_low), 1);
    pwr_fail = 1'b1;
    step(1);
    chk("R9 back to hold", int'(pull_low), 1);
    step(REC * TDIV + 4);
    chk("R9 hold persists", int'(pull_low), 1);
    power_return(1'b1, "R9 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule